// File: doc/BRIEF.md
# Power-Fail Write-Protect Chip-Enable Gate

This block sits between an address decoder and an external static RAM. It is synchronous and drives the RAM's active-low chip enable. While the supply is good, the decoder's enable reaches the RAM unchanged in the same cycle. When the supply fails, the RAM is write-protected by holding the enable high.

An access that is under way when the failure is reported may finish, but only within a bounded number of cycles. After the supply returns, the enable stays blocked for a fixed recovery period before pass-through resumes.

Supply monitoring is outside the block. Two digitized comparator flags arrive, one for each trip point, and a threshold-select bit chooses which of them counts as a power failure. Both timer lengths are parameters counted in clock cycles. All pins are plain control and status signals, so there is no streaming interface and no back-pressure.

Top module: `pfwp_ce_gate`

## Requirements
- R1: While reset is active, the block is in the protect state: state code 2, `ce_out_n` high and `forced_hi` high. It stays in protect until the selected failure flag is seen low.
- R2: In the pass state (code 0), `ce_out_n` equals `ce_in_n` within the same cycle.
- R3: With `thr_sel` low, the selected failure flag is `pf_trip[0]`, the 5% trip point at 4.62 V typical. With `thr_sel` high, it is `pf_trip[1]`, the 10% trip point at 4.37 V typical. The unselected bit has no effect.
- R4: If the selected flag is high in a pass-state cycle while `ce_in_n` is high, `ce_out_n` is high in that cycle. The next state is protect, and the output then stays high whatever `ce_in_n` does.
- R5: If the selected flag is high in a pass-state cycle while `ce_in_n` is low, the block enters the drain state (code 1). In drain, `ce_out_n` follows `ce_in_n` while it stays low. The first cycle with `ce_in_n` high is followed by the protect state.
- R6: The drain state lasts at most `WPT_CYC` cycles. After that the block moves to protect and drives `ce_out_n` high, even if `ce_in_n` is still low.
- R7: From protect, the first cycle in which the selected flag is low is followed by the recover state (code 3). Recover lasts exactly `REC_CYC` cycles with `ce_out_n` high and then gives way to pass.
- R8: If the selected flag goes high during recover, the next state is protect. The next recovery counts a full `REC_CYC` cycles again, starting from zero.
- R9: `state_code` reports pass=0, drain=1, protect=2, recover=3. `forced_hi` is high exactly in the protect and recover states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in_n | input | 1 | Raw active-low chip enable from the decoder |
| pf_trip | input | 2 | Comparator flags: bit0 is the 5% trip, bit1 is the 10% trip |
| thr_sel | input | 1 | Chooses which comparator flag means power failure |
| ce_out_n | output | 1 | Conditioned active-low chip enable to the RAM |
| state_code | output | 2 | Current control state |
| forced_hi | output | 1 | High while the enable is held inactive by protect or recover |

## Verification
Two events can land in the same cycle: the failure flag rising and the raw enable's level at that moment. Together they decide whether the block goes straight to protect or first drains an open access. The bench provokes both cases by raising the flag once with the enable high and once with it low. It judges the same-cycle output and then the state reported in the following cycles.

A second collision is a failure during the recovery count. The bench injects a failure mid-recovery and then measures whether the following recovery lasts the full length again.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
  typedef enum logic [1:0] {
    ST_PASS    = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfwp_state_e;
endpackage

// File: rtl/pfwp_trip_sel.sv
module pfwp_trip_sel #(
  parameter int N_TRIP = 2
) (
  input  logic [N_TRIP-1:0]         trip,
  input  logic [$clog2(N_TRIP)-1:0] sel,
  output logic                      fail
);
  always_comb fail = trip[sel];
endmodule

// File: rtl/pfwp_cycle_timer.sv
module pfwp_cycle_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (en && !done)   cnt <= cnt + 1'b1;
  end

  always_comb done = (cnt == LAST);

  AST_TMR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R6
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
  import pfwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_in_n,
  input  logic        pf,
  input  logic        wpt_done,
  input  logic        rec_done,
  output pfwp_state_e st,
  output logic        ce_out_n
);
  pfwp_state_e nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PROTECT;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      ST_PASS:    if (pf) nxt = ce_in_n ? ST_PROTECT : ST_DRAIN;
      ST_DRAIN:   if (ce_in_n || wpt_done) nxt = ST_PROTECT;
      ST_PROTECT: if (!pf) nxt = ST_RECOVER;
      ST_RECOVER: if (pf) nxt = ST_PROTECT;
                  else if (rec_done) nxt = ST_PASS;
      default:    nxt = ST_PROTECT;
    endcase
  end

  // Pass and drain hand the raw enable through; the others hold it inactive.
  always_comb ce_out_n = (st == ST_PASS || st == ST_DRAIN) ? ce_in_n : 1'b1;

  AST_IDLE_FAIL_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PASS && pf && ce_in_n) |=> (st == ST_PROTECT && ce_out_n)); // R4
  AST_DRAIN_ENDS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && ce_in_n) |=> (st == ST_PROTECT)); // R5
  AST_DRAIN_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && wpt_done) |=> (st == ST_PROTECT && ce_out_n)); // R6
  AST_POWER_BACK_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROTECT && !pf) |=> (st == ST_RECOVER)); // R7
  AST_REFAIL_REPROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOVER && pf) |=> (st == ST_PROTECT)); // R8
  AST_NO_EARLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOVER && !rec_done) |=> (st != ST_PASS)); // R7
endmodule

// File: rtl/pfwp_ce_gate.sv
module pfwp_ce_gate
  import pfwp_pkg::*;
#(
  parameter int WPT_CYC = 10000,
  parameter int REC_CYC = 8000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_in_n,
  input  logic [1:0] pf_trip,
  input  logic       thr_sel,
  output logic       ce_out_n,
  output logic [1:0] state_code,
  output logic       forced_hi
);
  logic        pf;
  logic        wpt_done;
  logic        rec_done;
  pfwp_state_e st;

  pfwp_trip_sel #(.N_TRIP(2)) u_sel (
    .trip (pf_trip),
    .sel  (thr_sel),
    .fail (pf)
  );

  pfwp_cycle_timer #(.LIMIT(WPT_CYC)) u_wpt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != ST_DRAIN),
    .en    (st == ST_DRAIN),
    .done  (wpt_done)
  );

  pfwp_cycle_timer #(.LIMIT(REC_CYC)) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != ST_RECOVER),
    .en    (st == ST_RECOVER),
    .done  (rec_done)
  );

  pfwp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_in_n  (ce_in_n),
    .pf       (pf),
    .wpt_done (wpt_done),
    .rec_done (rec_done),
    .st       (st),
    .ce_out_n (ce_out_n)
  );

  always_comb state_code = st;
  always_comb forced_hi  = (st == ST_PROTECT) || (st == ST_RECOVER);

  AST_RESET_PROTECT: assert property (@(posedge clk)
    !rst_n |=> (state_code == 2'd2 || !rst_n)); // R1
endmodule

// File: tb/pfwp_ce_gate_tb_top.sv
module pfwp_ce_gate_tb_top;
  localparam int WPT = 5;
  localparam int REC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_in_n = 1'b1;
  logic [1:0] pf_trip = 2'b01;
  logic       thr_sel = 1'b0;
  logic       ce_out_n;
  logic [1:0] state_code;
  logic       forced_hi;

  int n_chk = 0;
  int n_bad = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  pfwp_ce_gate #(.WPT_CYC(WPT), .REC_CYC(REC)) dut_i (
    .clk, .rst_n, .ce_in_n, .pf_trip, .thr_sel,
    .ce_out_n, .state_code, .forced_hi
  );

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic drv(input logic r, input logic ce, input logic [1:0] trip,
                     input logic sel, input logic eo, input logic [1:0] es,
                     input string tag);
    @(negedge clk);
    rst_n = r; ce_in_n = ce; pf_trip = trip; thr_sel = sel;
    exp_q.push_back({eo, es});
    tag_q.push_back(tag);
  endtask

  // Monitor: sample just before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        logic efh;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        efh = e[1];
        n_chk++;
        if ({ce_out_n, state_code} !== e || forced_hi !== efh) begin
          n_bad++;
          $display("FAIL %s: actual out=%b st=%0d fh=%b expected out=%b st=%0d fh=%b",
                   t, ce_out_n, state_code, forced_hi, e[2], e[1:0], efh);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  task automatic recover_then_pass(input logic sel, input string tag);
    drv(1, 0, 2'b00, sel, 1, 2'd2, tag);
    for (int i = 0; i < REC; i++) drv(1, 0, 2'b00, sel, 1, 2'd3, tag);
    drv(1, 0, 2'b00, sel, 0, 2'd0, tag);
  endtask

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) drv(0, 0, 2'b01, 0, 1, 2'd2, "R1 reset");
    drv(1, 0, 2'b01, 0, 1, 2'd2, "R1 hold protect while failing");
    // R7 recovery of exact length, R9 codes
    recover_then_pass(0, "R7 recovery window");
    // R2 pass-through
    drv(1, 1, 2'b00, 0, 1, 2'd0, "R2 pass high");
    drv(1, 0, 2'b00, 0, 0, 2'd0, "R2 pass low");
    // R3: unselected bit ignored
    drv(1, 0, 2'b10, 0, 0, 2'd0, "R3 sel0 ignores bit1");
    drv(1, 0, 2'b01, 1, 0, 2'd0, "R3 sel1 ignores bit0");
    drv(1, 0, 2'b01, 1, 0, 2'd0, "R3 sel1 still pass");
    // R4 fail while idle
    drv(1, 1, 2'b11, 1, 1, 2'd0, "R4 idle fail same cycle");
    drv(1, 0, 2'b11, 1, 1, 2'd2, "R4 protect ignores enable");
    drv(1, 0, 2'b11, 1, 1, 2'd2, "R4 protect held");
    // R8 refail during recover, then a full recovery again
    drv(1, 0, 2'b00, 1, 1, 2'd2, "R8 leave protect");
    for (int i = 0; i < 3; i++) drv(1, 0, 2'b00, 1, 1, 2'd3, "R8 partial recover");
    drv(1, 0, 2'b10, 1, 1, 2'd3, "R8 refail seen");
    drv(1, 0, 2'b10, 1, 1, 2'd2, "R8 back to protect");
    recover_then_pass(1, "R8 full recovery restarts");
    // R5 drain ended by release
    drv(1, 0, 2'b01, 0, 0, 2'd0, "R5 fail during access");
    drv(1, 0, 2'b01, 0, 0, 2'd1, "R5 drain follows");
    drv(1, 0, 2'b01, 0, 0, 2'd1, "R5 drain follows");
    drv(1, 1, 2'b01, 0, 1, 2'd1, "R5 release in drain");
    drv(1, 0, 2'b01, 0, 1, 2'd2, "R5 held after release");
    recover_then_pass(0, "R7 recovery after drain");
    // R6 drain timeout
    drv(1, 0, 2'b01, 0, 0, 2'd0, "R6 fail during access");
    for (int i = 0; i < WPT; i++) drv(1, 0, 2'b01, 0, 0, 2'd1, "R6 drain window");
    drv(1, 0, 2'b01, 0, 1, 2'd2, "R6 timeout forces high");
    drv(1, 0, 2'b01, 0, 1, 2'd2, "R6 stays protected");
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule